// File: doc/BRIEF.md
# Rotating-Ones RAM Self-Test Engine

This block is a built-in self-test sequencer for a small byte-wide character RAM with one synchronous port. A single pulse on `start` makes it walk every address from zero upward. At each address it first reads and keeps the byte that is stored there. It then writes a growing run of ones into that byte: one set bit, then two, and so on until every bit is set. After each write it reads the byte back, holds the returned value in a capture register, and compares it with the pattern it wrote. Once the full run has passed, it writes the kept byte back, so the memory holds the same data at the end as at the start.

The engine stops at the first mismatch. It raises `fail` and holds the address, the pattern it expected and the value it actually read, so that software or a tester can collect them after the run. `done` pulses for one cycle when a run ends, whether it passed or failed. `busy` covers the whole run. The RAM returns read data one clock after it samples the address, and the sequencer spends a wait cycle to allow for that latency.

Top module: `rot1_selftest_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done`, `fail` and `mem_we` are all low.
- R2: A `start` pulse while the engine is idle begins a run, and `busy` is high from the next cycle. A `start` pulse while `busy` is high has no effect: the run length and the sequence of writes do not change.
- R3: At each address the engine writes the DW step patterns 2^(k+1)-1 for k = 0..DW-1, in that order (0x01, 0x03, ... 0xFF for 8-bit data). Each new pattern keeps all bits of the previous pattern and adds the next higher bit.
- R4: Each address takes exactly 3 + 4*DW busy cycles, which is 35 for 8-bit data. That is one read of the original byte plus one wait cycle, then for each step a write, a read, a wait and a compare, then one restore write.
- R5: After the last step passes, the original byte that was read from the address is written back to it. The restore is the (DW+1)-th write to that address.
- R6: Addresses are visited in ascending order from 0 to DEPTH-1, and the address output only ever steps up by one during a run.
- R7: On the first compare where the read-back value differs from the pattern, the engine stops without restoring that byte. It sets `fail` and latches `fail_addr`, `fail_expected` (the pattern) and `fail_actual` (the value read).
- R8: `done` is high for exactly one cycle at the end of a run, both after a pass and on failure, and `busy` is low in that cycle. A passing run keeps `busy` high for DEPTH*(3+4*DW) cycles.
- R9: `fail` and its latched fields hold until the next accepted `start`, which clears `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a self-test run (ignored while busy) |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | DW | RAM read data, valid one cycle after the address |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of the first mismatch |
| fail_expected | output | DW | Pattern written at the first mismatch |
| fail_actual | output | DW | Value read back at the first mismatch |

## Verification
The assertions check, on every cycle, the handshake properties of the control outputs:
- `done` lasts a single cycle and never overlaps `busy`.
- Writes happen only during a run.
- A run starts at address zero.
- The address only increments by one.
- A rising `fail` comes with `done`.
- The failure record stays frozen while idle.

The bench's scenarios are needed for the properties that depend on data:
- The exact order of the step patterns.
- The restore of each original byte.
- The run length for each address.
- That a second `start` changes nothing.
- The failing address, expected value and actual value for stuck-at-zero and stuck-at-one bits placed at various addresses.

// File: rtl/rot1_pkg.sv
package rot1_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ORIG,
        ST_WAIT_ORIG,
        ST_WRITE,
        ST_RD_BACK,
        ST_WAIT_BACK,
        ST_COMPARE,
        ST_RESTORE,
        ST_END
    } seq_state_e;

    // Control strobes decoded from the sequencer state each cycle
    typedef struct packed {
        logic begin_run;
        logic keep_orig;
        logic grab_rd;
        logic we;
        logic use_orig;
        logic step_adv;
        logic step_clr;
        logic addr_adv;
        logic flag_fail;
    } seq_ctl_t;

    // Fixed busy cycles per address for a given data width
    function automatic int cycles_per_addr(input int dw);
        return 3 + 4 * dw;
    endfunction

endpackage

// File: rtl/rot1_addr_walker.sv
module rot1_addr_walker #(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          advance,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            addr_q <= '0;
        end else if (advance) begin
            addr_q <= addr_q + AW'(1);
        end
    end

    assign addr = addr_q;
    assign last = (addr_q == LAST_ADDR);
endmodule

// File: rtl/rot1_pattern_gen.sv
module rot1_pattern_gen #(
    parameter int DW = 8,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          advance,
    output logic [DW-1:0] pattern,
    output logic          last_step
);
    logic [SW-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            step_q <= '0;
        end else if (advance) begin
            step_q <= step_q + SW'(1);
        end
    end

    // Bit i is set once the step index has reached i: cumulative fill of ones
    for (genvar i = 0; i < DW; i++) begin : g_fill
        assign pattern[i] = (SW'(i) <= step_q);
    end

    assign last_step = (step_q == SW'(DW - 1));
endmodule

// File: rtl/rot1_result_latch.sv
module rot1_result_latch #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          capture,
    input  logic [AW-1:0] cur_addr,
    input  logic [DW-1:0] cur_expected,
    input  logic [DW-1:0] cur_actual,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_expected,
    output logic [DW-1:0] fail_actual
);
    logic          fail_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] exp_q;
    logic [DW-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail_q <= 1'b0;
            addr_q <= '0;
            exp_q  <= '0;
            act_q  <= '0;
        end else if (capture && !fail_q) begin
            fail_q <= 1'b1;
            addr_q <= cur_addr;
            exp_q  <= cur_expected;
            act_q  <= cur_actual;
        end
    end

    assign fail          = fail_q;
    assign fail_addr     = addr_q;
    assign fail_expected = exp_q;
    assign fail_actual   = act_q;
endmodule

// File: rtl/rot1_selftest_engine.sv
module rot1_selftest_engine
    import rot1_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_expected,
    output logic [DW-1:0] fail_actual
);
    localparam int SW = (DW > 1) ? $clog2(DW) : 1;

    seq_state_e    state_q, state_d;
    seq_ctl_t      ctl;
    logic [AW-1:0] addr;
    logic          addr_last;
    logic [DW-1:0] pattern;
    logic          step_last;
    logic [DW-1:0] orig_q;
    logic [DW-1:0] cap_q;
    logic          mismatch;

    rot1_addr_walker #(.DEPTH(DEPTH), .AW(AW)) i_walker (
        .clk     (clk),
        .rst     (rst),
        .clear   (ctl.begin_run),
        .advance (ctl.addr_adv),
        .addr    (addr),
        .last    (addr_last)
    );

    rot1_pattern_gen #(.DW(DW), .SW(SW)) i_pattern (
        .clk       (clk),
        .rst       (rst),
        .clear     (ctl.begin_run | ctl.step_clr),
        .advance   (ctl.step_adv),
        .pattern   (pattern),
        .last_step (step_last)
    );

    rot1_result_latch #(.AW(AW), .DW(DW)) i_result (
        .clk           (clk),
        .rst           (rst),
        .clear         (ctl.begin_run),
        .capture       (ctl.flag_fail),
        .cur_addr      (addr),
        .cur_expected  (pattern),
        .cur_actual    (cap_q),
        .fail          (fail),
        .fail_addr     (fail_addr),
        .fail_expected (fail_expected),
        .fail_actual   (fail_actual)
    );

    assign mismatch = (cap_q != pattern);

    // Sequencer: next state and control strobes
    always_comb begin
        state_d = state_q;
        ctl     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ctl.begin_run = 1'b1;
                    state_d       = ST_RD_ORIG;
                end
            end
            ST_RD_ORIG:   state_d = ST_WAIT_ORIG;
            ST_WAIT_ORIG: begin
                ctl.keep_orig = 1'b1;
                state_d       = ST_WRITE;
            end
            ST_WRITE: begin
                ctl.we  = 1'b1;
                state_d = ST_RD_BACK;
            end
            ST_RD_BACK:   state_d = ST_WAIT_BACK;
            ST_WAIT_BACK: begin
                ctl.grab_rd = 1'b1;
                state_d     = ST_COMPARE;
            end
            ST_COMPARE: begin
                if (mismatch) begin
                    ctl.flag_fail = 1'b1;
                    state_d       = ST_END;
                end else if (step_last) begin
                    state_d = ST_RESTORE;
                end else begin
                    ctl.step_adv = 1'b1;
                    state_d      = ST_WRITE;
                end
            end
            ST_RESTORE: begin
                ctl.we       = 1'b1;
                ctl.use_orig = 1'b1;
                ctl.step_clr = 1'b1;
                if (addr_last) begin
                    state_d = ST_END;
                end else begin
                    ctl.addr_adv = 1'b1;
                    state_d      = ST_RD_ORIG;
                end
            end
            ST_END:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Saved original byte and read-back capture register
    always_ff @(posedge clk) begin
        if (rst) begin
            orig_q <= '0;
            cap_q  <= '0;
        end else begin
            if (ctl.keep_orig) begin
                orig_q <= mem_rdata;
            end
            if (ctl.grab_rd) begin
                cap_q <= mem_rdata;
            end
        end
    end

    assign mem_addr  = addr;
    assign mem_we    = ctl.we;
    assign mem_wdata = ctl.use_orig ? orig_q : pattern;
    assign busy      = (state_q != ST_IDLE) && (state_q != ST_END);
    assign done      = (state_q == ST_END);
endmodule

// File: rtl/rot1_selftest_checker.sv
module rot1_selftest_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] fail_addr
);
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                      // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                      // R8
    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);                                                     // R2
    AST_RUN_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mem_addr == '0));                                    // R6
    AST_ADDR_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (mem_addr != $past(mem_addr)))
            |-> (mem_addr == $past(mem_addr) + AW'(1)));                      // R6
    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> done);                                                // R7
    AST_FAIL_HELD: assert property (@(posedge clk) disable iff (rst)
        (fail && !busy && !start) |=> (fail && $stable(fail_addr)));          // R9
endmodule

bind rot1_selftest_engine rot1_selftest_checker #(.AW(AW)) i_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .fail_addr (fail_addr)
);

// File: tb/test_rot1_selftest_engine.sv
module test_rot1_selftest_engine;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int CPA   = 3 + 4 * DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_expected, fail_actual;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    rot1_selftest_engine #(.DEPTH(DEPTH), .DW(DW)) i_rot1_selftest_engine (
        .clk(clk), .rst(rst), .start(start),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_expected(fail_expected),
        .fail_actual(fail_actual)
    );

    // RAM model with an injectable stuck-at fault on one address
    logic [DW-1:0] mem  [DEPTH];
    logic [DW-1:0] orig [DEPTH];
    int            flt_addr = -1;
    logic [DW-1:0] flt_s0 = '0;
    logic [DW-1:0] flt_s1 = '0;

    function automatic logic [DW-1:0] view(input int a, input logic [DW-1:0] v);
        if (a == flt_addr) return (v & ~flt_s0) | flt_s1;
        return v;
    endfunction

    function automatic logic [DW-1:0] pat(input int k);
        return DW'((1 << (k + 1)) - 1);
    endfunction

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= view(int'(mem_addr), mem[mem_addr]);
    end

    // Monitors: busy cycle count and write-sequence check (R3, R5, R6)
    int busy_cnt = 0;
    int wr_idx   = 0;
    int seq_err  = 0;
    int seq_bad_a = 0, seq_bad_d = 0, seq_exp_a = 0, seq_exp_d = 0;

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (busy) busy_cnt <= busy_cnt + 1;
        if (mem_we) begin
            automatic int a = wr_idx / (DW + 1);
            automatic int k = wr_idx % (DW + 1);
            automatic logic [DW-1:0] e = (k < DW) ? pat(k) : view(a, orig[a]);
            if (int'(mem_addr) != a || mem_wdata != e) begin
                if (seq_err == 0) begin
                    seq_bad_a = int'(mem_addr); seq_bad_d = int'(mem_wdata);
                    seq_exp_a = a; seq_exp_d = int'(e);
                end
                seq_err = seq_err + 1;
            end
            wr_idx = wr_idx + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    int seed = 3;

    task automatic run_case(input int fa, input logic [DW-1:0] s0,
                            input logic [DW-1:0] s1, input bit poke);
        bit exp_fail = 0;
        int exp_k = 0;
        logic [DW-1:0] exp_act = '0;
        int exp_busy, exp_wr, wd;
        flt_addr = fa; flt_s0 = s0; flt_s1 = s1;
        for (int a = 0; a < DEPTH; a++) begin
            mem[a]  = DW'(a * 29 + seed * 7 + 5);
            orig[a] = mem[a];
        end
        seed++;
        if (fa >= 0) begin
            for (int k = 0; k < DW; k++) begin
                if (!exp_fail && view(fa, pat(k)) != pat(k)) begin
                    exp_fail = 1; exp_k = k; exp_act = view(fa, pat(k));
                end
            end
        end
        exp_busy = exp_fail ? fa * CPA + 2 + 4 * (exp_k + 1) : DEPTH * CPA;
        exp_wr   = exp_fail ? fa * (DW + 1) + exp_k + 1 : DEPTH * (DW + 1);

        @(negedge clk);
        busy_cnt = 0; wr_idx = 0; seq_err = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !fail, "R2/R9", "busy set and fail cleared after start",
              {busy, fail}, 2'b10);
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wd = 0;
        while (!done && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        check(done, "R8", "run reached done", int'(done), 1);
        check(!busy, "R8", "busy low during done", int'(busy), 0);
        check(busy_cnt == exp_busy, "R4/R8", "busy cycle count", busy_cnt, exp_busy);
        check(fail == exp_fail, "R7", "fail flag", int'(fail), int'(exp_fail));
        if (exp_fail) begin
            check(int'(fail_addr) == fa, "R7", "fail_addr", int'(fail_addr), fa);
            check(fail_expected == pat(exp_k), "R7", "fail_expected",
                  int'(fail_expected), int'(pat(exp_k)));
            check(fail_actual == exp_act, "R7", "fail_actual",
                  int'(fail_actual), int'(exp_act));
        end
        @(negedge clk);
        check(!done, "R8", "done lasts one cycle", int'(done), 0);
        check(fail == exp_fail, "R9", "fail held after done", int'(fail), int'(exp_fail));
        check(wr_idx == exp_wr, "R3/R7", "number of writes", wr_idx, exp_wr);
        check(seq_err == 0, "R3/R5/R6", "write sequence (addr)", seq_bad_a, seq_exp_a);
        check(seq_err == 0, "R3/R5", "write sequence (data)", seq_bad_d, seq_exp_d);
        // Memory contents after the run (R5)
        for (int a = 0; a < DEPTH; a++) begin
            automatic logic [DW-1:0] e;
            if (exp_fail && a == fa)      e = pat(exp_k);
            else if (exp_fail && a > fa)  e = orig[a];
            else                          e = view(a, orig[a]);
            check(mem[a] == e, "R5", $sformatf("content of address %0d", a),
                  int'(mem[a]), int'(e));
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !fail && !mem_we, "R1", "outputs in reset",
              {busy, done, fail, mem_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !fail && !mem_we, "R1", "outputs after reset",
              {busy, done, fail, mem_we}, 0);

        run_case(-1, '0, '0, 1'b0);                 // clean pass
        run_case(-1, '0, '0, 1'b1);                 // R2: start while busy ignored
        for (int b = 0; b < DW; b++)                // R7: stuck-at-0 sweep
            run_case((b * 5 + 2) % DEPTH, DW'(1 << b), '0, 1'b0);
        for (int b = 1; b < DW; b++)                // R7: stuck-at-1 sweep
            run_case((b * 3) % DEPTH, '0, DW'(1 << b), 1'b0);
        run_case(0, DW'(8'h80), '0, 1'b0);          // first address fails
        run_case(DEPTH - 1, DW'(8'h01), '0, 1'b0);  // last address fails
        run_case(DEPTH - 1, '0, DW'(8'h01), 1'b0);  // stuck-1 on bit 0 passes
        run_case(-1, '0, '0, 1'b0);                 // R9: pass after a failure

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule